// File: doc/BRIEF.md
# Instruction Decoder with Immediate Generation

This block turns one 32-bit instruction word into the control and operand fields that the execute, branch and memory stages need. A class is read from the low-order prefix of the word. A two-bit prefix selects the immediate and register arithmetic classes. A three-bit prefix selects load, store, branch and jump. The block then extracts the operation code, up to three register indices and the multiply/divide sub-operation. It builds a sign-extended 32-bit immediate and raises a flag for any encoding that has no defined meaning, so that the pipeline can trap on it.

The decoder does not read registers, execute anything or change the program counter. The decode logic is combinational. The parameter `REG_OUT` selects whether a register stage sits on its outputs. The default is one registered stage with synchronous active-high reset.

Top module: `insn_decoder`

## Requirements
- R1: The class comes from the low bits. If bits[5:4] are 00 the class is immediate arithmetic (code 1), and if they are 01 it is register arithmetic (code 2). If bits[5:3] are 100, 101, 110 or 111 the class is load (3), store (4), branch (5) or jump (6).
- R2: The opcode output is bits[3:0] for the two arithmetic classes, and {0, bits[2:0]} for the other classes.
- R3: Source A is bits[15:11] for every class except jump, where it reads 0. The target is bits[10:6] for immediate, register, load and jump, and 0 otherwise. Source B is bits[20:16] for the register class, bits[10:6] for store and branch, and 0 otherwise.
- R4: For immediate, load, store and branch, the immediate is bits[31:16] sign-extended to 32 bits.
- R5: For jump, the immediate is bits[31:11] sign-extended to 32 bits. For the register class the immediate is 0.
- R6: The multiply/divide sub-op output is bits[23:21] for the register class and 0 for every other class.
- R7: Arithmetic opcodes 12, 13 and 14 are undefined in both arithmetic classes. Opcode 15 is undefined in the immediate class but defined in the register class.
- R8: A register-class word with any bit of [31:24] set is undefined. Its fields are still reported.
- R9: Store opcodes 4 to 7, branch opcodes 6 and 7, and jump opcodes 4 to 7 are undefined. Every load opcode is defined.
- R10: With `REG_OUT=1` (the default), every output reflects the word presented one clock earlier. While reset is high, every output is 0 at each clock edge, and this includes the class code 0 and the undefined flag.
- R11: Outside reset, exactly one of the six class flags is high, and it is the flag that matches the class code. This holds whether or not the word is undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 32 | Instruction word to decode |
| fmt_class_o | output | 3 | Class code: 1 imm, 2 reg, 3 load, 4 store, 5 branch, 6 jump, 0 only in reset |
| opcode_o | output | 4 | Operation within the class |
| rt_o | output | 5 | Target register index |
| ra_o | output | 5 | Source A register index |
| rb_o | output | 5 | Source B register index |
| mdsub_o | output | 3 | Multiply/divide sub-operation |
| imm_o | output | 32 | Sign-extended immediate |
| is_alu_imm_o | output | 1 | Immediate arithmetic class |
| is_alu_reg_o | output | 1 | Register arithmetic class |
| is_load_o | output | 1 | Load class |
| is_store_o | output | 1 | Store class |
| is_branch_o | output | 1 | Branch class |
| is_jump_o | output | 1 | Jump class |
| undef_o | output | 1 | Encoding has no defined meaning |

## Verification
The hardest cases are words that are undefined for a reason other than their opcode. A register-class word with a stray high bit, or with only bit 31 set, still decodes its source fields normally, so only the undefined flag reveals the fault. The stimulus table places these words next to well-formed register words that carry the same fields, and it pairs opcode 15 in both arithmetic classes. This separates a correct decoder from one that checks only the opcode. Sign-extension boundaries are exercised with the largest positive and the most negative 16-bit and 21-bit immediates.

// File: rtl/idec_pkg.sv
package idec_pkg;

    localparam int ILEN     = 32;
    localparam int RIDX_W   = 5;
    localparam int OP_W     = 4;
    localparam int MD_W     = 3;
    localparam int IMM_S_W  = 16;
    localparam int IMM_J_W  = 21;
    localparam int NKIND    = 6;
    localparam int ALU_RSV0 = 12;   // first unused arithmetic opcode
    localparam int ALU_RSV1 = 14;   // last unused arithmetic opcode
    localparam int HI_CHK_W = 8;    // register-form must-be-zero width

    typedef enum logic [2:0] {
        CLS_NONE   = 3'd0,
        CLS_IMM    = 3'd1,
        CLS_REG    = 3'd2,
        CLS_LOAD   = 3'd3,
        CLS_STORE  = 3'd4,
        CLS_BRANCH = 3'd5,
        CLS_JUMP   = 3'd6
    } cls_e;

    typedef struct packed {
        cls_e                   cls;
        logic [OP_W-1:0]        op;
        logic [RIDX_W-1:0]      rt;
        logic [RIDX_W-1:0]      ra;
        logic [RIDX_W-1:0]      rb;
        logic [MD_W-1:0]        md;
        logic [ILEN-1:0]        imm;
        logic [NKIND-1:0]       kind;
        logic                   undef;
    } dec_t;

    // Field sits in the top bits; arithmetic shift yields the sign-extended value.
    function automatic logic [ILEN-1:0] sext_top(input logic [ILEN-1:0] w, input int width);
        return $signed(w) >>> (ILEN - width);
    endfunction

    // Class code to one-hot flag vector: bit0 imm .. bit5 jump.
    function automatic logic [NKIND-1:0] kind_of(input cls_e c);
        logic [NKIND-1:0] k;
        k = '0;
        case (c)
            CLS_IMM:    k[0] = 1'b1;
            CLS_REG:    k[1] = 1'b1;
            CLS_LOAD:   k[2] = 1'b1;
            CLS_STORE:  k[3] = 1'b1;
            CLS_BRANCH: k[4] = 1'b1;
            CLS_JUMP:   k[5] = 1'b1;
            default:    k    = '0;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/idec_class.sv
module idec_class
    import idec_pkg::*;
(
    input  logic [HI_CHK_W-1:0] hi_i,
    input  logic [5:0]          lo_i,
    output cls_e                cls_o,
    output logic [OP_W-1:0]     op_o,
    output logic                undef_o
);

    logic hi_dirty;
    logic alu_rsv;

    assign hi_dirty = |hi_i;
    assign alu_rsv  = (int'(lo_i[3:0]) >= ALU_RSV0) && (int'(lo_i[3:0]) <= ALU_RSV1);

    always_comb begin
        if (!lo_i[5]) begin
            cls_o = lo_i[4] ? CLS_REG : CLS_IMM;
            op_o  = lo_i[3:0];
        end else begin
            case (lo_i[4:3])
                2'b00:   cls_o = CLS_LOAD;
                2'b01:   cls_o = CLS_STORE;
                2'b10:   cls_o = CLS_BRANCH;
                default: cls_o = CLS_JUMP;
            endcase
            op_o = {1'b0, lo_i[2:0]};
        end
    end

    always_comb begin
        case (cls_o)
            CLS_IMM:    undef_o = alu_rsv || (op_o == 4'hF);
            CLS_REG:    undef_o = alu_rsv || hi_dirty;
            CLS_STORE:  undef_o = op_o[2];
            CLS_BRANCH: undef_o = (op_o[2:1] == 2'b11);
            CLS_JUMP:   undef_o = op_o[2];
            default:    undef_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/idec_fields.sv
module idec_fields
    import idec_pkg::*;
(
    input  logic [ILEN-7:0]     body_i,
    input  cls_e                cls_i,
    output logic [RIDX_W-1:0]   rt_o,
    output logic [RIDX_W-1:0]   ra_o,
    output logic [RIDX_W-1:0]   rb_o,
    output logic [MD_W-1:0]     md_o,
    output logic [ILEN-1:0]     imm_o
);

    logic [ILEN-1:0] w;
    logic [ILEN-1:0] imm_s;
    logic [ILEN-1:0] imm_j;

    assign w     = {body_i, 6'b0};
    assign imm_s = sext_top(w, IMM_S_W);
    assign imm_j = sext_top(w, IMM_J_W);

    always_comb begin
        rt_o  = '0;
        ra_o  = '0;
        rb_o  = '0;
        md_o  = '0;
        imm_o = '0;
        case (cls_i)
            CLS_IMM, CLS_LOAD: begin
                rt_o  = w[10:6];
                ra_o  = w[15:11];
                imm_o = imm_s;
            end
            CLS_REG: begin
                rt_o = w[10:6];
                ra_o = w[15:11];
                rb_o = w[20:16];
                md_o = w[23:21];
            end
            CLS_STORE, CLS_BRANCH: begin
                ra_o  = w[15:11];
                rb_o  = w[10:6];
                imm_o = imm_s;
            end
            CLS_JUMP: begin
                rt_o  = w[10:6];
                imm_o = imm_j;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/idec_stage.sv
module idec_stage
    import idec_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  dec_t d_i,
    output dec_t q_o
);

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) q_o <= '0;
                else     q_o <= d_i;
            end
        end else begin : g_pass
            assign q_o = d_i;
        end
    endgenerate

endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
    import idec_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] insn_i,
    output logic [2:0]  fmt_class_o,
    output logic [3:0]  opcode_o,
    output logic [4:0]  rt_o,
    output logic [4:0]  ra_o,
    output logic [4:0]  rb_o,
    output logic [2:0]  mdsub_o,
    output logic [31:0] imm_o,
    output logic        is_alu_imm_o,
    output logic        is_alu_reg_o,
    output logic        is_load_o,
    output logic        is_store_o,
    output logic        is_branch_o,
    output logic        is_jump_o,
    output logic        undef_o
);

    cls_e            cls_c;
    logic [OP_W-1:0] op_c;
    logic            undef_c;
    dec_t            dec_c;
    dec_t            dec_q;

    idec_class i_class (
        .hi_i    (insn_i[ILEN-1 -: HI_CHK_W]),
        .lo_i    (insn_i[5:0]),
        .cls_o   (cls_c),
        .op_o    (op_c),
        .undef_o (undef_c)
    );

    idec_fields i_fields (
        .body_i (insn_i[ILEN-1:6]),
        .cls_i  (cls_c),
        .rt_o   (dec_c.rt),
        .ra_o   (dec_c.ra),
        .rb_o   (dec_c.rb),
        .md_o   (dec_c.md),
        .imm_o  (dec_c.imm)
    );

    assign dec_c.cls   = cls_c;
    assign dec_c.op    = op_c;
    assign dec_c.kind  = kind_of(cls_c);
    assign dec_c.undef = undef_c;

    idec_stage #(.REG_OUT(REG_OUT)) i_stage (
        .clk (clk),
        .rst (rst),
        .d_i (dec_c),
        .q_o (dec_q)
    );

    assign fmt_class_o  = dec_q.cls;
    assign opcode_o     = dec_q.op;
    assign rt_o         = dec_q.rt;
    assign ra_o         = dec_q.ra;
    assign rb_o         = dec_q.rb;
    assign mdsub_o      = dec_q.md;
    assign imm_o        = dec_q.imm;
    assign is_alu_imm_o = dec_q.kind[0];
    assign is_alu_reg_o = dec_q.kind[1];
    assign is_load_o    = dec_q.kind[2];
    assign is_store_o   = dec_q.kind[3];
    assign is_branch_o  = dec_q.kind[4];
    assign is_jump_o    = dec_q.kind[5];
    assign undef_o      = dec_q.undef;

    // Sub-op field only leaves the field extractor for the register class (R6).
    p_md_only_reg_r6: assert property (@(posedge clk) disable iff (rst)
        (cls_c != CLS_REG) |-> (dec_c.md == '0));

    // Stray high bits on a register word must reach the undefined flag (R8).
    p_reg_hi_undef_r8: assert property (@(posedge clk) disable iff (rst)
        ((cls_c == CLS_REG) && (insn_i[31:24] != 8'h00)) |-> undef_c);

    // 16-bit immediate classes: upper 17 bits all copies of the sign (R4).
    p_imm16_sign_r4: assert property (@(posedge clk) disable iff (rst)
        (cls_c inside {CLS_IMM, CLS_LOAD, CLS_STORE, CLS_BRANCH})
            |-> ((&dec_c.imm[31:15]) || !(|dec_c.imm[31:15])));

    // Jump immediate: upper 12 bits all copies of the sign (R5).
    p_immj_sign_r5: assert property (@(posedge clk) disable iff (rst)
        (cls_c == CLS_JUMP) |-> ((&dec_c.imm[31:20]) || !(|dec_c.imm[31:20])));

    // Exactly one class flag at the outputs once out of reset (R11).
    p_one_flag_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $onehot(dec_q.kind));

    // Load class never flags undefined (R9).
    p_load_defined_r9: assert property (@(posedge clk) disable iff (rst)
        (cls_c == CLS_LOAD) |-> !undef_c);

    generate
        if (REG_OUT) begin : g_chk_reg
            // One-cycle latency of the output stage (R10).
            p_stage_delay_r10: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (dec_q == $past(dec_c)));
        end
    endgenerate

endmodule

// File: tb/test_insn_decoder.sv
module test_insn_decoder;

    typedef struct packed {
        logic [31:0] insn;
        logic [2:0]  cls;
        logic [3:0]  op;
        logic [4:0]  rt;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [2:0]  md;
        logic [31:0] imm;
        logic        undef;
    } vec_t;

    function automatic logic [31:0] mk(input logic [15:0] hi, input logic [4:0] a,
                                       input logic [4:0] t, input logic [5:0] lo);
        return {hi, a, t, lo};
    endfunction

    function automatic logic [31:0] mkj(input logic [20:0] i21, input logic [4:0] t,
                                        input logic [5:0] lo);
        return {i21, t, lo};
    endfunction

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        // immediate arithmetic
        '{mk(16'h0005, 5'd3, 5'd7, 6'b000000), 3'd1, 4'h0, 5'd7, 5'd3, 5'd0, 3'd0, 32'h0000_0005, 1'b0},
        '{mk(16'h8000, 5'd31, 5'd1, 6'b000011), 3'd1, 4'h3, 5'd1, 5'd31, 5'd0, 3'd0, 32'hFFFF_8000, 1'b0},
        '{mk(16'hFFFF, 5'd2, 5'd4, 6'b001010), 3'd1, 4'hA, 5'd4, 5'd2, 5'd0, 3'd0, 32'hFFFF_FFFF, 1'b0},
        '{mk(16'h0010, 5'd1, 5'd1, 6'b001100), 3'd1, 4'hC, 5'd1, 5'd1, 5'd0, 3'd0, 32'h0000_0010, 1'b1},
        '{mk(16'h0000, 5'd0, 5'd2, 6'b001111), 3'd1, 4'hF, 5'd2, 5'd0, 5'd0, 3'd0, 32'h0000_0000, 1'b1},
        // register arithmetic
        '{mk(16'h0009, 5'd5, 5'd6, 6'b010000), 3'd2, 4'h0, 5'd6, 5'd5, 5'd9, 3'd0, 32'h0, 1'b0},
        '{mk(16'h00B1, 5'd8, 5'd9, 6'b011011), 3'd2, 4'hB, 5'd9, 5'd8, 5'd17, 3'd5, 32'h0, 1'b0},
        '{mk(16'h0002, 5'd3, 5'd31, 6'b011111), 3'd2, 4'hF, 5'd31, 5'd3, 5'd2, 3'd0, 32'h0, 1'b0},
        '{mk(16'h0004, 5'd3, 5'd3, 6'b011101), 3'd2, 4'hD, 5'd3, 5'd3, 5'd4, 3'd0, 32'h0, 1'b1},
        '{mk(16'h0100, 5'd5, 5'd6, 6'b010000), 3'd2, 4'h0, 5'd6, 5'd5, 5'd0, 3'd0, 32'h0, 1'b1},
        '{mk(16'h8003, 5'd5, 5'd6, 6'b010000), 3'd2, 4'h0, 5'd6, 5'd5, 5'd3, 3'd0, 32'h0, 1'b1},
        // load
        '{mk(16'hFFFC, 5'd4, 5'd8, 6'b100001), 3'd3, 4'h1, 5'd8, 5'd4, 5'd0, 3'd0, 32'hFFFF_FFFC, 1'b0},
        '{mk(16'h1234, 5'd0, 5'd9, 6'b100111), 3'd3, 4'h7, 5'd9, 5'd0, 5'd0, 3'd0, 32'h0000_1234, 1'b0},
        // store
        '{mk(16'h7FFF, 5'd10, 5'd12, 6'b101010), 3'd4, 4'h2, 5'd0, 5'd10, 5'd12, 3'd0, 32'h0000_7FFF, 1'b0},
        '{mk(16'h0001, 5'd1, 5'd2, 6'b101100), 3'd4, 4'h4, 5'd0, 5'd1, 5'd2, 3'd0, 32'h0000_0001, 1'b1},
        // branch
        '{mk(16'hFFF0, 5'd1, 5'd2, 6'b110101), 3'd5, 4'h5, 5'd0, 5'd1, 5'd2, 3'd0, 32'hFFFF_FFF0, 1'b0},
        '{mk(16'h0000, 5'd7, 5'd7, 6'b110110), 3'd5, 4'h6, 5'd0, 5'd7, 5'd7, 3'd0, 32'h0, 1'b1},
        // jump
        '{mkj(21'h10_0000, 5'd31, 6'b111000), 3'd6, 4'h0, 5'd31, 5'd0, 5'd0, 3'd0, 32'hFFF0_0000, 1'b0},
        '{mkj(21'h00_0000, 5'd0, 6'b111011), 3'd6, 4'h3, 5'd0, 5'd0, 5'd0, 3'd0, 32'h0, 1'b0},
        '{mkj(21'h0F_FFFF, 5'd4, 6'b111100), 3'd6, 4'h4, 5'd4, 5'd0, 5'd0, 3'd0, 32'h000F_FFFF, 1'b1},
        '{mkj(21'h00_0003, 5'd1, 6'b111111), 3'd6, 4'h7, 5'd1, 5'd0, 5'd0, 3'd0, 32'h0000_0003, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] insn = 32'h0;
    logic [2:0]  fmt_class;
    logic [3:0]  opcode;
    logic [4:0]  rt, ra, rb;
    logic [2:0]  mdsub;
    logic [31:0] imm;
    logic        f_imm, f_reg, f_load, f_store, f_branch, f_jump, undef;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    insn_decoder i_insn_decoder (
        .clk          (clk),
        .rst          (rst),
        .insn_i       (insn),
        .fmt_class_o  (fmt_class),
        .opcode_o     (opcode),
        .rt_o         (rt),
        .ra_o         (ra),
        .rb_o         (rb),
        .mdsub_o      (mdsub),
        .imm_o        (imm),
        .is_alu_imm_o (f_imm),
        .is_alu_reg_o (f_reg),
        .is_load_o    (f_load),
        .is_store_o   (f_store),
        .is_branch_o  (f_branch),
        .is_jump_o    (f_jump),
        .undef_o      (undef)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] flags_now();
        return {f_jump, f_branch, f_store, f_load, f_reg, f_imm};
    endfunction

    task automatic apply(input logic [31:0] w);
        @(negedge clk);
        insn = w;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R10: reset clears every output even with a live word on the input
        insn = mk(16'hFFFF, 5'd31, 5'd31, 6'b011111);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "reset class", {29'b0, fmt_class}, 32'd0);
        chk("R10", "reset imm", imm, 32'd0);
        chk("R10", "reset regs", {17'b0, rt, ra, rb}, 32'd0);
        chk("R10", "reset flags+undef", {25'b0, flags_now(), undef}, 32'd0);
        rst = 1'b0;

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9 R11
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].insn);
            chk("R1", $sformatf("v%0d class", i), {29'b0, fmt_class}, {29'b0, VECS[i].cls});
            chk("R2", $sformatf("v%0d opcode", i), {28'b0, opcode}, {28'b0, VECS[i].op});
            chk("R3", $sformatf("v%0d rt", i), {27'b0, rt}, {27'b0, VECS[i].rt});
            chk("R3", $sformatf("v%0d ra", i), {27'b0, ra}, {27'b0, VECS[i].ra});
            chk("R3", $sformatf("v%0d rb", i), {27'b0, rb}, {27'b0, VECS[i].rb});
            chk("R6", $sformatf("v%0d mdsub", i), {29'b0, mdsub}, {29'b0, VECS[i].md});
            chk((VECS[i].cls == 3'd6 || VECS[i].cls == 3'd2) ? "R5" : "R4",
                $sformatf("v%0d imm", i), imm, VECS[i].imm);
            chk("R7 R8 R9", $sformatf("v%0d undef", i), {31'b0, undef}, {31'b0, VECS[i].undef});
            chk("R11", $sformatf("v%0d flags", i), {26'b0, flags_now()},
                {26'b0, 6'b1 << (VECS[i].cls - 3'd1)});
        end

        // R10: output holds the previous word until the next edge
        apply(mk(16'h0005, 5'd3, 5'd7, 6'b000000));
        @(negedge clk);
        insn = mkj(21'h10_0000, 5'd31, 6'b111000);
        #5;
        chk("R10", "hold before edge class", {29'b0, fmt_class}, 32'd1);
        chk("R10", "hold before edge imm", imm, 32'h0000_0005);
        @(posedge clk);
        @(negedge clk);
        chk("R10", "after edge class", {29'b0, fmt_class}, 32'd6);
        chk("R10", "after edge imm", imm, 32'hFFF0_0000);

        // R10: reset in mid-run clears outputs again
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R10", "mid reset class", {29'b0, fmt_class}, 32'd0);
        chk("R10", "mid reset flags", {26'b0, flags_now()}, 32'd0);
        rst = 1'b0;

        // R8: every single high bit [31:24] alone makes a register word undefined
        for (int b = 24; b < 32; b++) begin
            apply(32'h0000_0010 | (32'h1 << b));
            chk("R8", $sformatf("hi bit %0d undef", b), {31'b0, undef}, 32'd1);
        end

        // R9: all eight load opcodes defined
        for (int o = 0; o < 8; o++) begin
            apply(mk(16'h0000, 5'd1, 5'd1, {3'b100, 3'(o)}));
            chk("R9", $sformatf("load op %0d undef", o), {31'b0, undef}, 32'd0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule